// File: doc/BRIEF.md
# Sign-Recovering Binary-Weight Accumulator

This block sums, row after row, the signed products of an unsigned multi-bit activation and a weight that is either +1 or −1. It never sees the weight itself. Each row it is given the activation and the bitwise XNOR of that activation with the row's weight bit, as a sense stage would deliver it. A +1 weight leaves every bit of the activation unchanged. A −1 weight inverts every bit.

The block works out the weight sign from the two least significant bits alone. It widens the product to the accumulator width, filling the upper bits with the sign, and adds it into a registered sum through a ripple-carry chain of one-bit full adders. The recovered sign also drives the chain's carry-in. For a negative weight this completes the two's-complement negation: the inverted activation plus one. The sum wraps modulo 2^ACC_W. A sticky flag records any row whose exact signed result fell outside the accumulator's range. An active-low asynchronous clear empties both the sum and the flag.

Top module: `sign_recover_acc`

## Requirements
- R1: While `clr_n` is low, `acc_out` and `ovf_flag` are 0. The clear takes effect without waiting for a clock edge and wins over `in_valid`.
- R2: The weight is taken as negative exactly when bit 0 of `act_in` differs from bit 0 of `xnor_in`, and as positive when they are equal.
- R3: On a valid row with a positive weight (`xnor_in == act_in`), the sum increases by the zero-extended activation.
- R4: On a valid row with a negative weight (`xnor_in == ~act_in`), the sum decreases by the activation. The added term is the inverted, one-filled activation, and the carry-in is 1.
- R5: On a clock edge where `in_valid` is low, `acc_out` and `ovf_flag` keep their values whatever `act_in` and `xnor_in` carry.
- R6: The sum is kept modulo 2^ACC_W. A result above 127 or below −128 (default widths) wraps around.
- R7: `ovf_flag` is set by a valid row whose exact signed result lies outside −2^(ACC_W−1) to 2^(ACC_W−1)−1. Once set, it stays set until a clear.
- R8: Each valid row is visible on `acc_out` after exactly one rising clock edge.
- R9: A negative weight with a zero activation leaves the sum unchanged and does not set `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous active-low clear of the sum and the flag |
| in_valid | input | 1 | Row present; the sum is updated on this edge |
| act_in | input | ACT_W | Unsigned activation |
| xnor_in | input | ACT_W | Bitwise XNOR of the activation with the weight bit |
| acc_out | output | ACC_W | Registered two's-complement running sum |
| ovf_flag | output | 1 | Sticky signed-overflow indicator |

## Verification
The bench builds the block with its default widths: 6-bit activations and an 8-bit sum. With these widths three full-scale products of the same sign already cross the signed range in either direction, so wrap-around and the sticky flag are reached in a few rows. A zero activation with a negative weight drives a carry through every stage of the chain. Random rows mixing both signs, idle cycles and occasional clears are compared each cycle against an integer model that knows nothing of the carry chain.

// File: rtl/sra_pkg.sv
package sra_pkg;

  // One-bit full adder, sum output
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // One-bit full adder, carry output (majority of the three inputs)
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Weight polarity from the low bits: a mismatch means the product was inverted
  function automatic logic weight_negative(input logic act_lsb, input logic prod_lsb);
    return act_lsb ^ prod_lsb;
  endfunction

  // Signed overflow of a ripple sum: carry into the top stage differs from carry out
  function automatic logic signed_overflow(input logic carry_into_msb, input logic carry_out);
    return carry_into_msb ^ carry_out;
  endfunction

endpackage

// File: rtl/sra_sign_detect.sv
module sra_sign_detect (
  input  logic act_lsb,
  input  logic prod_lsb,
  output logic neg
);
  import sra_pkg::*;

  always_comb begin
    neg = weight_negative(act_lsb, prod_lsb);
  end
endmodule

// File: rtl/sra_term_former.sv
module sra_term_former #(
  parameter int ACT_W = 6,
  parameter int ACC_W = 8
) (
  input  logic [ACT_W-1:0] prod,
  input  logic             neg,
  output logic [ACC_W-1:0] term,
  output logic             cin
);
  localparam int EXT_W = ACC_W - ACT_W;

  // The upper bits are the inversion of the zero extension: ones for a
  // negative weight, zeros for a positive one.
  generate
    if (EXT_W > 0) begin : g_extend
      always_comb begin
        term = {{EXT_W{neg}}, prod};
      end
    end else begin : g_trunc
      always_comb begin
        term = prod[ACC_W-1:0];
      end
    end
  endgenerate

  // The carry-in supplies the "+1" of the two's-complement negation
  always_comb begin
    cin = neg;
  end
endmodule

// File: rtl/sra_ripple_adder.sv
module sra_ripple_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry_msb_in,
  output logic         carry_out
);
  import sra_pkg::*;

  logic [W:0] chain;

  always_comb begin
    chain[0] = cin;
  end

  // One full adder per bit; the carry ripples from bit 0 upward
  generate
    for (genvar i = 0; i < W; i++) begin : g_stage
      always_comb begin
        sum[i]     = fa_sum(a[i], b[i], chain[i]);
        chain[i+1] = fa_carry(a[i], b[i], chain[i]);
      end
    end
  endgenerate

  always_comb begin
    carry_msb_in = chain[W-1];
    carry_out    = chain[W];
  end
endmodule

// File: rtl/sra_acc_reg.sv
module sra_acc_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         en,
  input  logic [W-1:0] d,
  input  logic         ovf_in,
  output logic [W-1:0] q,
  output logic         ovf_q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q     <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      q     <= d;
      ovf_q <= ovf_q | ovf_in;
    end
  end
endmodule

// File: rtl/sign_recover_acc.sv
module sign_recover_acc #(
  parameter int ACT_W = 6,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             in_valid,
  input  logic [ACT_W-1:0] act_in,
  input  logic [ACT_W-1:0] xnor_in,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf_flag
);
  import sra_pkg::*;

  // Named internal events, visible to the bound checker
  logic             sign_neg;
  logic [ACC_W-1:0] term;
  logic             carry_in;
  logic [ACC_W-1:0] next_sum;
  logic             c_msb_in;
  logic             c_out;
  logic             step_ovf;

  sra_sign_detect u_sign (
    .act_lsb  (act_in[0]),
    .prod_lsb (xnor_in[0]),
    .neg      (sign_neg)
  );

  sra_term_former #(
    .ACT_W (ACT_W),
    .ACC_W (ACC_W)
  ) u_term (
    .prod (xnor_in),
    .neg  (sign_neg),
    .term (term),
    .cin  (carry_in)
  );

  sra_ripple_adder #(
    .W (ACC_W)
  ) u_add (
    .a            (acc_out),
    .b            (term),
    .cin          (carry_in),
    .sum          (next_sum),
    .carry_msb_in (c_msb_in),
    .carry_out    (c_out)
  );

  always_comb begin
    step_ovf = signed_overflow(c_msb_in, c_out);
  end

  sra_acc_reg #(
    .W (ACC_W)
  ) u_reg (
    .clk    (clk),
    .clr_n  (clr_n),
    .en     (in_valid),
    .d      (next_sum),
    .ovf_in (step_ovf),
    .q      (acc_out),
    .ovf_q  (ovf_flag)
  );
endmodule

// File: rtl/sra_checker.sv
module sra_checker #(
  parameter int ACT_W = 6,
  parameter int ACC_W = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic             in_valid,
  input logic [ACT_W-1:0] act_in,
  input logic [ACT_W-1:0] xnor_in,
  input logic [ACC_W-1:0] acc_out,
  input logic             ovf_flag,
  input logic             sign_neg
);
  logic [ACC_W-1:0] act_ext;
  logic [ACC_W-1:0] plus_ref;
  logic [ACC_W-1:0] minus_ref;

  always_comb begin
    act_ext   = ACC_W'(act_in);
    plus_ref  = acc_out + act_ext;
    minus_ref = acc_out - act_ext;
  end

  // R1: the clear holds both outputs at zero
  p_clear_zero_r1: assert property (@(posedge clk)
    !clr_n |-> (acc_out == '0 && !ovf_flag));

  // R2: a fully inverted product marks the weight negative; an unchanged one, positive
  p_sign_neg_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (xnor_in == ~act_in) |-> sign_neg);
  p_sign_pos_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (xnor_in == act_in) |-> !sign_neg);

  // R3: a positive row adds the activation
  p_add_pos_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (in_valid && xnor_in == act_in) |=> acc_out == $past(plus_ref));

  // R4: a negative row subtracts the activation
  p_add_neg_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (in_valid && xnor_in == ~act_in) |=> acc_out == $past(minus_ref));

  // R5: idle edges change nothing
  p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !in_valid |=> ($stable(acc_out) && $stable(ovf_flag)));

  // R7: the overflow flag is sticky
  p_sticky_r7: assert property (@(posedge clk) disable iff (!clr_n)
    ovf_flag |=> ovf_flag);
endmodule

bind sign_recover_acc sra_checker #(
  .ACT_W (ACT_W),
  .ACC_W (ACC_W)
) chk_i (
  .clk      (clk),
  .clr_n    (clr_n),
  .in_valid (in_valid),
  .act_in   (act_in),
  .xnor_in  (xnor_in),
  .acc_out  (acc_out),
  .ovf_flag (ovf_flag),
  .sign_neg (sign_neg)
);

// File: tb/sign_recover_acc_tb_top.sv
module sign_recover_acc_tb_top;
  localparam int ACT_W = 6;
  localparam int ACC_W = 8;
  localparam int SMAX  = (1 << (ACC_W - 1)) - 1;
  localparam int SMIN  = -(1 << (ACC_W - 1));
  localparam int MODV  = 1 << ACC_W;

  logic             clk = 1'b0;
  logic             clr_n = 1'b1;
  logic             in_valid = 1'b0;
  logic [ACT_W-1:0] act_in = '0;
  logic [ACT_W-1:0] xnor_in = '0;
  logic [ACC_W-1:0] acc_out;
  logic             ovf_flag;

  int checks = 0;
  int errors = 0;
  int model_sum = 0;
  bit model_ovf = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sign_recover_acc #(.ACT_W(ACT_W), .ACC_W(ACC_W)) dut_i (
    .clk      (clk),
    .clr_n    (clr_n),
    .in_valid (in_valid),
    .act_in   (act_in),
    .xnor_in  (xnor_in),
    .acc_out  (acc_out),
    .ovf_flag (ovf_flag)
  );

  function automatic int as_signed(input logic [ACC_W-1:0] v);
    int r;
    r = int'(v);
    if (r > SMAX) r = r - MODV;
    return r;
  endfunction

  task automatic check_state(input string req);
    checks++;
    if (as_signed(acc_out) != model_sum || ovf_flag != model_ovf) begin
      errors++;
      $display("FAIL %s: acc=%0d ovf=%0d expected acc=%0d ovf=%0d",
               req, as_signed(acc_out), ovf_flag, model_sum, model_ovf);
    end
  endtask

  // Drive one row at a falling edge; compare at the next falling edge
  task automatic row(input bit v, input int act, input bit neg, input string req);
    int s;
    in_valid = v;
    act_in   = ACT_W'(act);
    xnor_in  = neg ? ~ACT_W'(act) : ACT_W'(act);
    if (v) begin
      s = model_sum + (neg ? -act : act);
      if (s > SMAX || s < SMIN) model_ovf = 1'b1;
      s = ((s - SMIN) % MODV + MODV) % MODV + SMIN;
      model_sum = s;
    end
    @(posedge clk);
    @(negedge clk);
    check_state(req);
  endtask

  task automatic do_clear(input string req);
    clr_n = 1'b0;
    in_valid = 1'b1;
    act_in = 6'd17;
    xnor_in = 6'd17;
    model_sum = 0;
    model_ovf = 1'b0;
    #1;
    check_state(req);
    @(posedge clk);
    @(negedge clk);
    check_state(req);
    clr_n = 1'b1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_clear("R1 reset");

    row(1, 5, 0, "R3 positive add");
    row(1, 3, 1, "R4 negative add");
    row(1, 0, 1, "R9 zero negative");
    row(1, 63, 1, "R4 full-scale negative");
    row(0, 42, 0, "R5 idle positive pattern");
    row(0, 21, 1, "R5 idle negative pattern");
    row(1, 1, 0, "R8 one-edge latency");

    do_clear("R1 clear");
    row(1, 63, 0, "R3 step 1");
    row(1, 63, 0, "R3 step 2");
    row(1, 63, 0, "R6 R7 positive wrap");
    row(1, 10, 1, "R7 flag stays set");
    row(0, 0, 0, "R5 R7 idle keeps flag");

    do_clear("R1 clear drops flag");
    row(1, 63, 1, "R4 step 1");
    row(1, 63, 1, "R4 step 2");
    row(1, 63, 1, "R6 R7 negative wrap");
    row(1, 0, 1, "R9 zero negative after wrap");

    do_clear("R1 clear");
    for (int k = 0; k < 2; k++) row(1, 63, 1, "R4 toward minimum");
    row(1, 2, 1, "R7 exactly minimum no flag");
    row(1, 0, 1, "R9 at minimum");
    row(1, 1, 1, "R7 one below minimum");

    for (int n = 0; n < 400; n++) begin
      if (($urandom % 50) == 0) begin
        do_clear("R1 random clear");
      end else begin
        row(($urandom % 4) != 0, int'($urandom % 64), bit'($urandom % 2), "R2 random row");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule